// File: doc/BRIEF.md
# Pseudo-Associative Read Cache Controller

This block manages a direct-mapped array of cache lines that is treated as two halves. A read first looks at the line selected by the plain index. When the stored tag matches, the word returns one cycle after the request is taken. When it does not match, the controller looks at a second slot. That slot is the same set in the other half, found by inverting the top index bit. A match there is a slower hit and takes two cycles. When both slots miss, the controller fetches the word from the next memory level and answers once the refill arrives.

Lines move so that the block that was just used sits in its home slot. A slow hit swaps the two lines. A refill takes the home slot, and the line it displaces moves to the alternate slot, where it can still be found by the second probe. Each stored tag carries the top index bit of the block's own address. This lets a line sitting in a slot that is not its home be told apart from the home block of that slot. The controller only reads and refills. It handles one request at a time.

All streams are valid/ready. A transfer happens on a clock edge where valid and ready are both high. A response is held, unchanged, until `rsp_ready` is seen high. No new request is taken until that response is gone. A memory request is held, unchanged, until `mem_req_ready` is seen high. The controller accepts refill data only while it waits for it.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address is a miss. With `rst` low and no traffic, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A read whose block is in its home slot (index = address bits IDX_W-1:0) returns that word with `rsp_kind` = 0. `rsp_valid` rises on the clock edge right after the edge that accepted the request, which is a latency of 1.
- R3: A read whose block is in the alternate slot (home index with bit IDX_W-1 inverted) returns that word with `rsp_kind` = 1. `rsp_valid` rises two edges after the accepting edge, which is a latency of 2.
- R4: A read that misses in both slots drives `mem_req_addr` equal to the request address. It returns the refill word with `rsp_kind` = 2. `rsp_valid` rises on the edge after the edge that takes the refill beat. With G cycles of grant wait and D cycles of data wait from the memory, the latency is 4+G+D.
- R5: After a slow hit the two lines swap. The next read of the same block is a latency-1 hit, and the line that had been in the home slot is now found with a slow hit.
- R6: On a miss the refilled block goes into the home slot. If the home slot held a valid line, that line moves to the alternate slot and the old alternate line is dropped. If the home slot was empty, the alternate slot is left as it was.
- R7: A stored tag is the address bits above the index together with the block's own index bit IDX_W-1. A block whose alternate slot holds a line with equal upper bits but a different index top bit misses.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_kind` hold their values. `req_ready` is 0 from the accepting edge until the response has been taken.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` stays 1 and `mem_req_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W | Word read |
| rsp_kind | output | 2 | 0 fast hit, 1 slow hit, 2 miss |
| mem_req_valid | output | 1 | Refill request present |
| mem_req_ready | input | 1 | Memory takes the refill request |
| mem_req_addr | output | ADDR_W | Address to refill |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_ready | output | 1 | Controller takes the refill word |
| mem_rsp_data | input | DATA_W | Refill word |

## Verification
The bench runs a fixed sequence on blocks that share the same home and alternate slots. It covers first touches, repeated reads, reads straight after a swap, and reads of a line that was displaced and then dropped. Each response's kind and latency show which slot held the block, so the sequence shows where every line moved. Two blocks differ only in the top index bit and share their upper address bits. Reading them shows that a line sitting in another block's alternate slot is not taken as a match. The memory model uses a different grant delay and data delay for each miss, so the measured miss latency shows that both waits are counted. A run with the response held back checks that the response is stable and that no new request is taken.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    K_HIT    = 2'd0,
    K_PSEUDO = 2'd1,
    K_MISS   = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ALT,
    S_MREQ,
    S_MWAIT,
    S_RESP
  } state_e;

endpackage

// File: rtl/pac_addr.sv
module pac_addr #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  localparam int TAGX_W = ADDR_W - IDX_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  home_slot,
  output logic [IDX_W-1:0]  alt_slot,
  output logic [TAGX_W-1:0] want_tag
);

  localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

  assign home_slot = addr[IDX_W-1:0];
  assign alt_slot  = addr[IDX_W-1:0] ^ FLIP;
  // upper address bits plus the block's own top index bit
  assign want_tag  = {addr[ADDR_W-1:IDX_W], addr[IDX_W-1]};

endmodule

// File: rtl/pac_match.sv
module pac_match #(
  parameter int TAGX_W = 13
) (
  input  logic              line_valid,
  input  logic [TAGX_W-1:0] line_tag,
  input  logic [TAGX_W-1:0] want_tag,
  output logic              hit
);

  assign hit = line_valid && (line_tag == want_tag);

endmodule

// File: rtl/pac_store.sv
module pac_store #(
  parameter int SLOT_W = 4,
  parameter int TAGX_W = 13,
  parameter int DATA_W = 32,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0][SLOT_W-1:0] rd_slot,
  output logic [1:0]             rd_valid,
  output logic [1:0][TAGX_W-1:0] rd_tag,
  output logic [1:0][DATA_W-1:0] rd_data,
  input  logic [1:0]             wr_en,
  input  logic [1:0][SLOT_W-1:0] wr_slot,
  input  logic [1:0]             wr_valid,
  input  logic [1:0][TAGX_W-1:0] wr_tag,
  input  logic [1:0][DATA_W-1:0] wr_data
);

  logic [SLOTS-1:0]  vld;
  logic [TAGX_W-1:0] tags [SLOTS];
  logic [DATA_W-1:0] words [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (wr_en[p]) vld[wr_slot[p]] <= wr_valid[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (wr_en[p]) begin
        tags[wr_slot[p]]  <= wr_tag[p];
        words[wr_slot[p]] <= wr_data[p];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd_valid[p] = vld[rd_slot[p]];
    assign rd_tag[p]   = tags[rd_slot[p]];
    assign rd_data[p]  = words[rd_slot[p]];
  end

endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req_valid,
  input  logic  hit_home,
  input  logic  hit_alt,
  input  logic  home_valid,
  input  logic  mem_req_ready,
  input  logic  mem_rsp_valid,
  input  logic  rsp_ready,
  output logic  req_ready,
  output logic  addr_load,
  output logic  mem_req_valid,
  output logic  mem_rsp_ready,
  output logic  rsp_valid,
  output logic  rsp_load,
  output kind_e rsp_kind_d,
  output logic  wr_swap,
  output logic  wr_fill,
  output logic  wr_move
);

  state_e state, state_d;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_d;
  end

  always_comb begin
    state_d       = state;
    req_ready     = 1'b0;
    addr_load     = 1'b0;
    mem_req_valid = 1'b0;
    mem_rsp_ready = 1'b0;
    rsp_valid     = 1'b0;
    rsp_load      = 1'b0;
    rsp_kind_d    = K_HIT;
    wr_swap       = 1'b0;
    wr_fill       = 1'b0;
    wr_move       = 1'b0;
    case (state)
      S_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          addr_load = 1'b1;
          if (hit_home) begin
            rsp_load = 1'b1;
            state_d  = S_RESP;
          end else begin
            state_d = S_ALT;
          end
        end
      end
      S_ALT: begin
        if (hit_alt) begin
          rsp_load   = 1'b1;
          rsp_kind_d = K_PSEUDO;
          wr_swap    = 1'b1;
          state_d    = S_RESP;
        end else begin
          state_d = S_MREQ;
        end
      end
      S_MREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = S_MWAIT;
      end
      S_MWAIT: begin
        mem_rsp_ready = 1'b1;
        if (mem_rsp_valid) begin
          rsp_load   = 1'b1;
          rsp_kind_d = K_MISS;
          wr_fill    = 1'b1;
          wr_move    = home_valid;
          state_d    = S_RESP;
        end
      end
      S_RESP: begin
        rsp_valid = 1'b1;
        if (rsp_ready) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
  import pac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_kind,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int TAGX_W = ADDR_W - IDX_W + 1;

  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic [IDX_W-1:0]  home_slot, alt_slot;
  logic [TAGX_W-1:0] want_tag;

  logic [1:0][IDX_W-1:0]  rd_slot;
  logic [1:0]             rd_valid;
  logic [1:0][TAGX_W-1:0] rd_tag;
  logic [1:0][DATA_W-1:0] rd_data;
  logic [1:0]             probe_hit;

  logic [1:0]             wr_en;
  logic [1:0][IDX_W-1:0]  wr_slot;
  logic [1:0]             wr_valid;
  logic [1:0][TAGX_W-1:0] wr_tag;
  logic [1:0][DATA_W-1:0] wr_data;

  logic  addr_load, rsp_load, wr_swap, wr_fill, wr_move;
  kind_e rsp_kind_d, rsp_kind_q;
  logic [DATA_W-1:0] rsp_data_q;

  // the request is probed directly while idle, the held copy afterwards
  assign cur_addr = req_ready ? req_addr : addr_q;

  pac_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .addr      (cur_addr),
    .home_slot (home_slot),
    .alt_slot  (alt_slot),
    .want_tag  (want_tag)
  );

  assign rd_slot[0] = home_slot;
  assign rd_slot[1] = alt_slot;

  pac_store #(.SLOT_W(IDX_W), .TAGX_W(TAGX_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_slot  (rd_slot),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_valid (wr_valid),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data)
  );

  for (genvar p = 0; p < 2; p++) begin : g_probe
    pac_match #(.TAGX_W(TAGX_W)) u_match (
      .line_valid (rd_valid[p]),
      .line_tag   (rd_tag[p]),
      .want_tag   (want_tag),
      .hit        (probe_hit[p])
    );
  end

  pac_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .hit_home      (probe_hit[0]),
    .hit_alt       (probe_hit[1]),
    .home_valid    (rd_valid[0]),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_ready     (rsp_ready),
    .req_ready     (req_ready),
    .addr_load     (addr_load),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .rsp_valid     (rsp_valid),
    .rsp_load      (rsp_load),
    .rsp_kind_d    (rsp_kind_d),
    .wr_swap       (wr_swap),
    .wr_fill       (wr_fill),
    .wr_move       (wr_move)
  );

  // port 0 writes the home slot: refill word or the line found in the alternate
  assign wr_en[0]    = wr_swap | wr_fill;
  assign wr_slot[0]  = home_slot;
  assign wr_valid[0] = wr_fill ? 1'b1 : rd_valid[1];
  assign wr_tag[0]   = wr_fill ? want_tag : rd_tag[1];
  assign wr_data[0]  = wr_fill ? mem_rsp_data : rd_data[1];

  // port 1 writes the alternate slot with the old home line
  assign wr_en[1]    = wr_swap | wr_move;
  assign wr_slot[1]  = alt_slot;
  assign wr_valid[1] = rd_valid[0];
  assign wr_tag[1]   = rd_tag[0];
  assign wr_data[1]  = rd_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (addr_load) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data_q <= '0;
      rsp_kind_q <= K_HIT;
    end else if (rsp_load) begin
      rsp_kind_q <= rsp_kind_d;
      case (rsp_kind_d)
        K_HIT:    rsp_data_q <= rd_data[0];
        K_PSEUDO: rsp_data_q <= rd_data[1];
        default:  rsp_data_q <= mem_rsp_data;
      endcase
    end
  end

  assign rsp_data     = rsp_data_q;
  assign rsp_kind     = rsp_kind_q;
  assign mem_req_addr = addr_q;

endmodule

// File: rtl/pac_chk.sv
module pac_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        rsp_kind,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready
);

  p_hit_lat_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(rsp_valid) && rsp_kind == 2'd0) |-> $past(req_valid && req_ready));

  p_pseudo_lat_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(rsp_valid) && rsp_kind == 2'd1) |-> $past(req_valid && req_ready, 2));

  p_miss_resp_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(rsp_valid) && rsp_kind == 2'd2) |-> $past(mem_rsp_valid && mem_rsp_ready));

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_kind)));

  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  p_memreq_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

bind pseudo_assoc_cache pac_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pseudo_assoc_cache_test.sv
module pseudo_assoc_cache_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic [1:0]    rsp_kind;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pseudo_assoc_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) uut (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .rsp_kind      (rsp_kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int mem_grant_wait = 0;
  int mem_data_wait = 0;
  logic [AW-1:0] exp_mem_addr = '0;

  logic [DW-1:0] q_data [$];
  logic [1:0]    q_kind [$];
  int            q_acc  [$];
  int            q_lat  [$];
  string         q_req  [$];

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each new response against the scoreboard
  initial begin
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rsp_valid && !prev) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R8", "response with nothing outstanding", 64'(rsp_data), 64'd0);
        end else begin
          logic [DW-1:0] ed;
          logic [1:0]    ek;
          int ea, el;
          string rq;
          ed = q_data.pop_front();
          ek = q_kind.pop_front();
          ea = q_acc.pop_front();
          el = q_lat.pop_front();
          rq = q_req.pop_front();
          check(rsp_kind == ek, rq, "kind", 64'(rsp_kind), 64'(ek));
          check(rsp_data == ed, rq, "data", 64'(rsp_data), 64'(ed));
          check((cyc - ea + 1) == el, rq, "latency", 64'(cyc - ea + 1), 64'(el));
        end
      end
      prev = rsp_valid;
    end
  end

  // memory model with programmable grant and data waits
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [AW-1:0] a;
        a = mem_req_addr;
        check(a == exp_mem_addr, "R4", "refill address", 64'(a), 64'(exp_mem_addr));
        for (int i = 0; i < mem_grant_wait; i++) begin
          @(negedge clk);
          check(mem_req_valid && mem_req_addr == a, "R9", "request held",
                64'({mem_req_valid, mem_req_addr}), 64'({1'b1, a}));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (mem_data_wait) @(negedge clk);
        mem_rsp_data  = mem_word(a);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // driver: issue one read, queue its expectation, see the response taken
  task automatic rd(input logic [AW-1:0] a, input logic [1:0] kind,
                    input string req, input int hold);
    int lat;
    logic [DW-1:0] d0;
    lat = (kind == 2'd0) ? 1 : (kind == 2'd1) ? 2 : 4 + mem_grant_wait + mem_data_wait;
    exp_mem_addr = a;
    @(negedge clk);
    rsp_ready = (hold == 0);
    req_addr  = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    q_data.push_back(mem_word(a));
    q_kind.push_back(kind);
    q_acc.push_back(cyc + 1);
    q_lat.push_back(lat);
    q_req.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d0 = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == d0 && !req_ready, "R8", "held response",
            64'({rsp_valid, req_ready, rsp_data}), 64'({1'b1, 1'b0, d0}));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    while (rsp_valid) @(negedge clk);
  endtask

  localparam logic [AW-1:0] BA = 16'h0123;  // home 3
  localparam logic [AW-1:0] BB = 16'h012B;  // home B, same upper bits as BA
  localparam logic [AW-1:0] BC = 16'h0453;  // home 3
  localparam logic [AW-1:0] BD = 16'h045B;  // home B, same upper bits as BC
  localparam logic [AW-1:0] BE = 16'h0777;  // unrelated set

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);

    mem_grant_wait = 2; mem_data_wait = 1;
    rd(BA, 2'd2, "R1", 0);
    rd(BA, 2'd0, "R2", 0);
    mem_grant_wait = 0; mem_data_wait = 0;
    rd(BB, 2'd2, "R7", 0);
    rd(BA, 2'd0, "R6", 0);
    rd(BB, 2'd0, "R2", 0);
    mem_grant_wait = 1; mem_data_wait = 3;
    rd(BC, 2'd2, "R4", 0);
    rd(BC, 2'd0, "R6", 0);
    rd(BA, 2'd1, "R3", 0);
    rd(BA, 2'd0, "R5", 0);
    rd(BC, 2'd1, "R5", 0);
    mem_grant_wait = 0; mem_data_wait = 1;
    rd(BB, 2'd2, "R6", 0);
    rd(BA, 2'd0, "R6", 0);
    rd(BB, 2'd0, "R6", 0);
    mem_grant_wait = 0; mem_data_wait = 2;
    rd(BC, 2'd2, "R6", 0);
    rd(BC, 2'd0, "R8", 3);
    rd(BA, 2'd1, "R3", 0);
    mem_grant_wait = 3; mem_data_wait = 0;
    rd(BE, 2'd2, "R9", 0);
    rd(BE, 2'd0, "R2", 0);
    mem_grant_wait = 1; mem_data_wait = 1;
    rd(BD, 2'd2, "R7", 0);
    rd(BD, 2'd0, "R2", 0);

    repeat (3) @(negedge clk);
    check(q_data.size() == 0, "R8", "responses outstanding", 64'(q_data.size()), 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule